// File: doc/BRIEF.md
# External Memory Bus Cycle Generator

This block sequences the external bus of a small microcontroller core that talks to off-chip code and data memory over a multiplexed low-address/data bus. A free-running phase counter splits time into machine cycles of 12 oscillator clocks. At the end of each machine cycle the block takes one request from the core: none, code fetch, data read or data write. It also takes the address for that request. During the next machine cycle it drives the address-latch pulse, the code-read strobe, the memory chip select and the data read/write strobes.

The block decides whether a code fetch is served internally or externally, using a level sampled from the external-access pin while reset is held. Data strobes are suppressed for the address window that belongs to on-chip registers. The low and high address bytes are steered onto the two general-purpose port outputs in place of their port register values. Idle and power-down inputs force fixed levels on the latch pulse and the code strobe. Configuration inputs can silence the latch pulse and can turn the chip select into a general-purpose output.

Top module: `xbus_cycle_gen`

## Requirements
- R1: The phase runs 0..11 and repeats. The address-latch output `ale_o` is high in phases 0-1 and 6-7 of every machine cycle, whether or not a request is active, and low in the other phases.
- R2: In a read or write machine cycle (request code 2'b10 or 2'b11), the second latch pulse (phases 6-7) is omitted and the first one stays.
- R3: In a fetch cycle (request code 2'b01) that goes external, `psen_n_o` is low in phases 3-5 and 9-11. An internal fetch leaves it high.
- R4: The external-access pin is sampled on every clock while `rst_n` is low and is held afterwards. Later changes on the pin have no effect. With the held value high, fetches at addresses above 16'h3FFF are external and the rest are internal. With the held value low, every fetch is external.
- R5: In a read cycle, `rd_n_o` is low in phases 5-10, unless the address is 16'h7FF0 or higher. In a write cycle, `wr_n_o` is low in phases 5-10, unless the address lies in 16'h7FF0..16'h7FFF.
- R6: `mem_cs_n_o` is low for the whole of an external fetch cycle and high otherwise. When `cfg_cs_gpio_i` is 1, it follows `cs_gpio_val_i` at all times instead. This includes idle, power-down and reset.
- R7: During an external cycle (an external fetch, a read or a write) with `loaden_i` high, `p1_o` carries address bits 7:0. Otherwise it carries `p1_sfr_i`.
- R8: During an external cycle, when the held access level is low or `cfg_addren_i` is 1, `p2_o[6:0]` carries address bits 14:8. Otherwise `p2_o[6:0]` carries `p2_sfr_i[6:0]`. `p2_o[7]` always carries `p2_sfr_i[7]`.
- R9: While `idle_i` is high and `pd_i` is low, `ale_o` and `psen_n_o` are high. `rd_n_o` and `wr_n_o` are high, and so is `mem_cs_n_o` unless it is in general-purpose mode. A request offered at a boundary during idle is discarded, and the next cycle carries no request.
- R10: While `pd_i` is high, `ale_o` and `psen_n_o` are both low, and the data strobes are high. `pd_i` takes precedence over `idle_i`. Requests are discarded as in idle.
- R11: `cfg_ale_off_i` = 1 holds `ale_o` low when not in idle or power-down.
- R12: Request type and address are captured only on the clock edge that ends phase 11. Changes at other times do not affect the running cycle.
- R13: While `rst_n` is low, the phase is 0 and no request is held. `ale_o` is low and `psen_n_o`, `rd_n_o` and `wr_n_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 2 | Request: 00 none, 01 fetch, 10 read, 11 write |
| addr_i | input | 16 | Code or data address of the request |
| ea_pin_i | input | 1 | External-access pin, sampled during reset |
| loaden_i | input | 1 | Enables low address byte onto port 1 |
| idle_i | input | 1 | Idle mode status |
| pd_i | input | 1 | Power-down status |
| cfg_addren_i | input | 1 | Enables high address bits onto port 2 when access level is high |
| cfg_ale_off_i | input | 1 | Silences the latch pulse |
| cfg_cs_gpio_i | input | 1 | Chip select used as general-purpose output |
| cs_gpio_val_i | input | 1 | Level driven on chip select in general-purpose mode |
| p1_sfr_i | input | 8 | Port 1 register value |
| p2_sfr_i | input | 8 | Port 2 register value |
| ale_o | output | 1 | Address-latch enable |
| psen_n_o | output | 1 | Code-read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| mem_cs_n_o | output | 1 | Memory chip select, active low |
| p1_o | output | 8 | Port 1 pin value |
| p2_o | output | 8 | Port 2 pin value |

## Verification
If the phase counter drifts, the latch pulse moves or widens within the next clock. The per-clock comparison against an independent model then catches it at once. If a request is captured at the wrong moment, or the wrong address is held, it shows as early or late strobes, or as a wrong byte on the port outputs within the same machine cycle. If the sampled access level is wrong, a wrong internal/external decision shows on the code strobe and chip select in the first fetch cycle at an address near 16'h3FFF/16'h4000. Window errors show as a data strobe firing at 16'h7FF0, 16'h7FFF or 16'hFFFF, or missing at 16'h8000 or 16'h7FEF.

// File: rtl/xbus_pkg.sv
// Package: shared request encoding for the external bus cycle generator.
// Assumes the request code is fixed as listed (bench relies on it).
package xbus_pkg;
    typedef enum logic [1:0] {
        REQ_NONE  = 2'b00,
        REQ_FETCH = 2'b01,
        REQ_READ  = 2'b10,
        REQ_WRITE = 2'b11
    } xreq_e;
endpackage

// File: rtl/xbus_phase_ctr.sv
// Phase counter: counts oscillator clocks 0..CYCLE_LEN-1 and flags the last
// phase of a machine cycle. Assumes CYCLE_LEN >= 2.
module xbus_phase_ctr #(
    parameter int CYCLE_LEN = 12,
    parameter int PH_W      = $clog2(CYCLE_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] ph,
    output logic            last
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYCLE_LEN - 1);

    // Last phase of the machine cycle.
    assign last = (ph == PH_LAST);

    // Advance the phase, wrapping at the cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n)     ph <= '0;
        else if (last)  ph <= '0;
        else            ph <= ph + 1'b1;
    end
endmodule

// File: rtl/xbus_cycle_reg.sv
// Cycle register: samples the access pin during reset, captures the request
// at the machine-cycle boundary and decides internal versus external code.
// Assumes requests are discarded while idle or powered down.
module xbus_cycle_reg
    import xbus_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int INT_LIMIT = 16'h3FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ea_pin,
    input  logic              last,
    input  logic              idle,
    input  logic              pd,
    input  xreq_e             req,
    input  logic [ADDR_W-1:0] addr,
    output xreq_e             cyc_type,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic              ea_q,
    output logic              code_ext
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(INT_LIMIT);

    // Hold the access level seen while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) ea_q <= ea_pin;
    end

    // Capture request type and address at the cycle boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_type <= REQ_NONE;
            cyc_addr <= '0;
        end else if (last) begin
            cyc_type <= (idle || pd) ? REQ_NONE : req;
            cyc_addr <= addr;
        end
    end

    // Code space above the internal limit, or any code with access low.
    assign code_ext = !ea_q || (cyc_addr > LIMIT);
endmodule

// File: rtl/xbus_strobe_gen.sv
// Strobe generator: decodes the phase and current cycle into the latch pulse,
// code strobe, data strobes and chip select, then applies reset, idle,
// power-down and configuration overrides. Assumes an even CYCLE_LEN with two
// latch slots per machine cycle.
module xbus_strobe_gen
    import xbus_pkg::*;
#(
    parameter int CYCLE_LEN = 12,
    parameter int PH_W      = $clog2(CYCLE_LEN),
    parameter int ADDR_W    = 16,
    parameter int WIN_LO    = 16'h7FF0,
    parameter int WIN_HI_WR = 16'h7FFF
) (
    input  logic              rst_n,
    input  logic [PH_W-1:0]   ph,
    input  xreq_e             cyc_type,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              code_ext,
    input  logic              idle,
    input  logic              pd,
    input  logic              ale_off,
    input  logic              cs_gpio,
    input  logic              cs_gpio_val,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              mem_cs_n
);
    localparam int SLOTS    = 2;
    localparam int HALF     = CYCLE_LEN / SLOTS;
    localparam int ALE_W    = 2;
    localparam int PSEN_OFS = ALE_W + 1;
    localparam int PSEN_W   = 3;
    localparam int STB_OFS  = ALE_W + 3;
    localparam int STB_W    = 6;
    localparam logic [ADDR_W-1:0] W_LO = ADDR_W'(WIN_LO);
    localparam logic [ADDR_W-1:0] W_HI = ADDR_W'(WIN_HI_WR);

    logic [SLOTS-1:0] ale_slot;
    logic [SLOTS-1:0] psen_slot;
    logic             stb_win;
    logic             is_fetch, is_data, ext_fetch;
    logic             rd_ok, wr_ok;

    // One latch window and one code-strobe window per half cycle.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam int BASE = s * HALF;
        assign ale_slot[s]  = (ph >= PH_W'(BASE)) && (ph < PH_W'(BASE + ALE_W));
        assign psen_slot[s] = (ph >= PH_W'(BASE + PSEN_OFS)) &&
                              (ph < PH_W'(BASE + PSEN_OFS + PSEN_W));
    end

    // Data strobe window after the first latch pulse.
    assign stb_win = (ph >= PH_W'(STB_OFS)) && (ph < PH_W'(STB_OFS + STB_W));

    // Cycle classification and register-window qualification.
    assign is_fetch  = (cyc_type == REQ_FETCH);
    assign is_data   = (cyc_type == REQ_READ) || (cyc_type == REQ_WRITE);
    assign ext_fetch = is_fetch && code_ext;
    assign rd_ok     = (cyc_type == REQ_READ) && (cyc_addr < W_LO);
    assign wr_ok     = (cyc_type == REQ_WRITE) &&
                       !((cyc_addr >= W_LO) && (cyc_addr <= W_HI));

    // Latch pulse: power-down low, idle high, config off, data skips slot 1.
    always_comb begin
        if (!rst_n || pd)  ale = 1'b0;
        else if (idle)     ale = 1'b1;
        else if (ale_off)  ale = 1'b0;
        else               ale = ale_slot[0] || (ale_slot[1] && !is_data);
    end

    // Code strobe: power-down forces low, idle and reset force high.
    always_comb begin
        if (!rst_n)        psen_n = 1'b1;
        else if (pd)       psen_n = 1'b0;
        else if (idle)     psen_n = 1'b1;
        else               psen_n = !(ext_fetch && (|psen_slot));
    end

    // Data strobes, inactive in reset, idle and power-down.
    always_comb begin
        rd_n = 1'b1;
        wr_n = 1'b1;
        if (rst_n && !idle && !pd) begin
            rd_n = !(rd_ok && stb_win);
            wr_n = !(wr_ok && stb_win);
        end
    end

    // Chip select, or a plain driven level in general-purpose mode.
    always_comb begin
        if (cs_gpio)                     mem_cs_n = cs_gpio_val;
        else if (!rst_n || idle || pd)   mem_cs_n = 1'b1;
        else                             mem_cs_n = !ext_fetch;
    end
endmodule

// File: rtl/xbus_port_mux.sv
// Port mux: replaces port register values by address bytes during external
// cycles. Assumes ADDR_W >= 15 and 8-bit ports.
module xbus_port_mux #(
    parameter int ADDR_W = 16,
    parameter int PORT_W = 8
) (
    input  logic              ext_cyc,
    input  logic              loaden,
    input  logic              hi_en,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [PORT_W-1:0] p1_sfr,
    input  logic [PORT_W-1:0] p2_sfr,
    output logic [PORT_W-1:0] p1,
    output logic [PORT_W-1:0] p2
);
    localparam int HI_BITS = PORT_W - 1;

    logic lo_sel, hi_sel;

    // Steering selects for each port.
    assign lo_sel = ext_cyc && loaden;
    assign hi_sel = ext_cyc && hi_en;

    // Low address byte onto port 1.
    assign p1 = lo_sel ? cyc_addr[PORT_W-1:0] : p1_sfr;

    // Upper address bits onto port 2, top bit always from the register.
    for (genvar b = 0; b < PORT_W; b++) begin : g_p2
        if (b < HI_BITS) begin : g_addr
            assign p2[b] = hi_sel ? cyc_addr[PORT_W + b] : p2_sfr[b];
        end else begin : g_keep
            assign p2[b] = p2_sfr[b];
        end
    end
endmodule

// File: rtl/xbus_cycle_gen.sv
// Top: external memory bus cycle generator. Ties the phase counter, cycle
// register, strobe generator and port mux together. Assumes one request per
// machine cycle offered by the core and held around the cycle boundary.
module xbus_cycle_gen
    import xbus_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PORT_W    = 8,
    parameter int CYCLE_LEN = 12,
    parameter int INT_LIMIT = 16'h3FFF,
    parameter int WIN_LO    = 16'h7FF0,
    parameter int WIN_HI_WR = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ea_pin_i,
    input  logic              loaden_i,
    input  logic              idle_i,
    input  logic              pd_i,
    input  logic              cfg_addren_i,
    input  logic              cfg_ale_off_i,
    input  logic              cfg_cs_gpio_i,
    input  logic              cs_gpio_val_i,
    input  logic [PORT_W-1:0] p1_sfr_i,
    input  logic [PORT_W-1:0] p2_sfr_i,
    output logic              ale_o,
    output logic              psen_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              mem_cs_n_o,
    output logic [PORT_W-1:0] p1_o,
    output logic [PORT_W-1:0] p2_o
);
    localparam int PH_W = $clog2(CYCLE_LEN);

    logic [PH_W-1:0]   ph_q;
    logic              last_ph;
    xreq_e             cyc_type;
    logic [ADDR_W-1:0] cyc_addr;
    logic              ea_q;
    logic              code_ext;
    logic              ext_cyc;

    xbus_phase_ctr #(.CYCLE_LEN(CYCLE_LEN), .PH_W(PH_W)) u_ph (
        .clk(clk), .rst_n(rst_n), .ph(ph_q), .last(last_ph)
    );

    xbus_cycle_reg #(.ADDR_W(ADDR_W), .INT_LIMIT(INT_LIMIT)) u_cyc (
        .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin_i), .last(last_ph),
        .idle(idle_i), .pd(pd_i), .req(xreq_e'(req_i)), .addr(addr_i),
        .cyc_type(cyc_type), .cyc_addr(cyc_addr), .ea_q(ea_q),
        .code_ext(code_ext)
    );

    xbus_strobe_gen #(
        .CYCLE_LEN(CYCLE_LEN), .PH_W(PH_W), .ADDR_W(ADDR_W),
        .WIN_LO(WIN_LO), .WIN_HI_WR(WIN_HI_WR)
    ) u_stb (
        .rst_n(rst_n), .ph(ph_q), .cyc_type(cyc_type), .cyc_addr(cyc_addr),
        .code_ext(code_ext), .idle(idle_i), .pd(pd_i),
        .ale_off(cfg_ale_off_i), .cs_gpio(cfg_cs_gpio_i),
        .cs_gpio_val(cs_gpio_val_i), .ale(ale_o), .psen_n(psen_n_o),
        .rd_n(rd_n_o), .wr_n(wr_n_o), .mem_cs_n(mem_cs_n_o)
    );

    // A cycle that puts an address on the external bus.
    assign ext_cyc = ((cyc_type == REQ_FETCH) && code_ext) ||
                     (cyc_type == REQ_READ) || (cyc_type == REQ_WRITE);

    xbus_port_mux #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_port (
        .ext_cyc(ext_cyc), .loaden(loaden_i), .hi_en(!ea_q || cfg_addren_i),
        .cyc_addr(cyc_addr), .p1_sfr(p1_sfr_i), .p2_sfr(p2_sfr_i),
        .p1(p1_o), .p2(p2_o)
    );
endmodule

// File: rtl/xbus_cycle_chk.sv
// Checker: temporal properties of the bus cycle generator, bound to the top.
// Assumes the default 12-clock machine cycle and 16-bit addresses.
module xbus_cycle_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  ph,
    input logic [1:0]  cyc_type,
    input logic [15:0] cyc_addr,
    input logic        ea_q,
    input logic        idle,
    input logic        pd,
    input logic        ale,
    input logic        psen_n,
    input logic        rd_n,
    input logic        wr_n
);
    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph < 4'd12);

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == 4'd11) |=> (ph == 4'd0));

    // R2
    data_skip_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type[1] && !idle && !pd && (ph == 4'd6 || ph == 4'd7)) |-> !ale);

    // R3
    psen_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd && !psen_n) |-> (rd_n && wr_n));

    // R4
    ea_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(ea_q));

    // R5
    rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (cyc_addr < 16'h7FF0));

    // R5
    wr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !((cyc_addr >= 16'h7FF0) && (cyc_addr <= 16'h7FFF)));

    // R9
    idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !pd) |-> (ale && psen_n && rd_n && wr_n));

    // R10
    pd_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> (!ale && !psen_n));

    // R12
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != 4'd11) |=> ($stable(cyc_addr) && $stable(cyc_type)));
endmodule

bind xbus_cycle_gen xbus_cycle_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ph(ph_q), .cyc_type(cyc_type),
    .cyc_addr(cyc_addr), .ea_q(ea_q), .idle(idle_i), .pd(pd_i),
    .ale(ale_o), .psen_n(psen_n_o), .rd_n(rd_n_o), .wr_n(wr_n_o)
);

// File: tb/xbus_cycle_gen_tb.sv
// Bench: behavioural per-clock model of the bus cycle generator, compared on
// every falling edge against all outputs.
module xbus_cycle_gen_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]  req = 2'b00;
    logic [15:0] addr = 16'h0;
    logic ea_pin = 1'b1, loaden = 1'b0, idle = 1'b0, pd = 1'b0;
    logic addren = 1'b0, ale_off = 1'b0, cs_gpio = 1'b0, cs_val = 1'b0;
    logic [7:0] p1_sfr = 8'hA5, p2_sfr = 8'h3C;
    logic ale, psen_n, rd_n, wr_n, cs_n;
    logic [7:0] p1, p2;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int m_ph = 0;
    int m_type = 0;
    int m_addr = 0;
    bit m_ea = 1;

    always #2 clk = ~clk;

    xbus_cycle_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr),
        .ea_pin_i(ea_pin), .loaden_i(loaden), .idle_i(idle), .pd_i(pd),
        .cfg_addren_i(addren), .cfg_ale_off_i(ale_off),
        .cfg_cs_gpio_i(cs_gpio), .cs_gpio_val_i(cs_val),
        .p1_sfr_i(p1_sfr), .p2_sfr_i(p2_sfr), .ale_o(ale),
        .psen_n_o(psen_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
        .mem_cs_n_o(cs_n), .p1_o(p1), .p2_o(p2)
    );

    // Model update on each rising edge (inputs only change after falling edges).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_type = 0; m_addr = 0; m_ea = ea_pin;
        end else begin
            if (m_ph == 11) begin
                m_type = (idle || pd) ? 0 : int'(req);
                m_addr = int'(addr);
            end
            m_ph = (m_ph == 11) ? 0 : m_ph + 1;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at t=%0t ph=%0d: actual=%0h expected=%0h",
                     tag, $time, m_ph, act, exp);
        end
    endtask

    // Expected values from the requirements, compared every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            bit ext_f, ext_c, e_ale, e_psen, e_rd, e_wr, e_cs;
            int e_p1, e_p2;
            ext_f = (m_type == 1) && (!m_ea || m_addr >= 'h4000);
            ext_c = ext_f || m_type >= 2;
            if (!rst_n || pd)  e_ale = 0;
            else if (idle)     e_ale = 1;
            else if (ale_off)  e_ale = 0;
            else e_ale = (m_ph <= 1) || ((m_ph == 6 || m_ph == 7) && m_type < 2);
            if (!rst_n)        e_psen = 1;
            else if (pd)       e_psen = 0;
            else if (idle)     e_psen = 1;
            else e_psen = !(ext_f && ((m_ph >= 3 && m_ph <= 5) || m_ph >= 9));
            e_rd = 1; e_wr = 1;
            if (rst_n && !idle && !pd && m_ph >= 5 && m_ph <= 10) begin
                if (m_type == 2 && m_addr < 'h7FF0) e_rd = 0;
                if (m_type == 3 && !(m_addr >= 'h7FF0 && m_addr <= 'h7FFF)) e_wr = 0;
            end
            if (cs_gpio)                    e_cs = cs_val;
            else if (!rst_n || idle || pd)  e_cs = 1;
            else                            e_cs = !ext_f;
            e_p1 = (ext_c && loaden) ? (m_addr % 256) : int'(p1_sfr);
            e_p2 = int'(p2_sfr);
            if (ext_c && (!m_ea || addren))
                e_p2 = (int'(p2_sfr) & 'h80) | ((m_addr / 256) & 'h7F);
            check("R1 R2 R9 R10 R11 R13 ale", int'(ale), int'(e_ale));
            check("R3 R4 R9 R10 psen", int'(psen_n), int'(e_psen));
            check("R5 R12 rd", int'(rd_n), int'(e_rd));
            check("R5 R12 wr", int'(wr_n), int'(e_wr));
            check("R6 cs", int'(cs_n), int'(e_cs));
            check("R7 p1", int'(p1), e_p1);
            check("R8 p2", int'(p2), e_p2);
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic issue(logic [1:0] t, logic [15:0] a);
        req = t; addr = a;
        wait_clk(24);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;                     // R13 reset state checked above
        wait_clk(12);                     // R1 free-running ALE, no request
        issue(2'b01, 16'h0100);           // R3 internal fetch
        issue(2'b01, 16'h3FFF);           // R4 boundary internal
        issue(2'b01, 16'h4000);           // R4 boundary external
        loaden = 1'b1;
        issue(2'b01, 16'hC2D7);           // R7 low byte steered
        addren = 1'b1;
        issue(2'b10, 16'h1234);           // R2 R5 read, R8 high bits
        issue(2'b10, 16'h7FEF);
        issue(2'b10, 16'h7FF0);           // R5 read suppressed
        issue(2'b10, 16'hFFFF);
        issue(2'b11, 16'h7FFF);           // R5 write suppressed
        issue(2'b11, 16'h8000);
        issue(2'b11, 16'h7FEF);
        addren = 1'b0;
        ea_pin = 1'b0;                    // R4 ignored after reset
        issue(2'b01, 16'h0020);
        // R12 mid-cycle changes
        req = 2'b10; addr = 16'h5555;
        for (int i = 0; i < 30; i++) begin
            wait_clk(5);
            addr = addr + 16'h0111;
            req = req + 2'b01;
        end
        req = 2'b01; addr = 16'h9000;
        wait_clk(7);
        idle = 1'b1;                      // R9
        wait_clk(20);
        idle = 1'b0;
        wait_clk(14);
        cs_gpio = 1'b1; cs_val = 1'b0;    // R6 gpio mode
        wait_clk(6);
        pd = 1'b1;                        // R10
        wait_clk(15);
        idle = 1'b1;
        wait_clk(6);
        pd = 1'b0; idle = 1'b0; cs_val = 1'b1;
        wait_clk(13);
        cs_gpio = 1'b0;
        ale_off = 1'b1;                   // R11
        issue(2'b11, 16'h2222);
        ale_off = 1'b0;
        // second reset with access pin low: all fetches external
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        ea_pin = 1'b1;
        issue(2'b01, 16'h0010);           // R4 external with held low level
        issue(2'b10, 16'h4321);           // R8 high bits with access low
        loaden = 1'b0;
        issue(2'b01, 16'h1111);
        req = 2'b00;
        wait_clk(12);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule